// File: doc/BRIEF.md
# Lockable Banked Memory Window Mapper

This block sits between a 64 KB host bus window and a larger video memory. Each host access offset is turned into a full memory address by putting a bank number, counted in 64 KB units, above the 16-bit offset. Reads and writes can use different bank numbers. The bank numbers, the banking mode and the installed memory size live in a small set of extended control registers. These registers are reached through an index/data port: an index, a write strobe and write data go in, and read data comes out for the indexed register.

The extended registers are guarded by a key register. Writing the key value opens them. Writing any other value closes them. Reading the key register returns a signature that shows the lock state. While the registers are closed, writes to them are dropped and reads of them return zero. The stored values still drive the address mapping, so host traffic keeps working.

A mode bit selects one of two bank layouts. In split layout, the read bank and the write bank each have their own register with a 6-bit bank number. In packed layout, one register holds both banks as two nibbles.

Top module: `bank_window_mapper`

## Requirements
- R1: After reset the key register (index 0) reads A1h, and every extended register (indices 1 to 5) holds 00h, which selects packed layout, banking off and a 1 MB memory.
- R2: A write of 86h to index 0 opens the extended registers, after which index 0 reads 21h. A write of any other value to index 0 closes them, after which index 0 reads A1h.
- R3: While the registers are closed, writes to indices 1 to 5 leave them unchanged, and reads of indices 1 to 7 return 00h.
- R4: While the registers are open, all 8 bits written to indices 1 to 5 read back unchanged, and indices 6 and 7 read 00h.
- R5: A register write takes effect at the next clock edge. A read of the same index in the cycle of the write returns the old value.
- R6: While bit 0 of index 1 (bank enable) is 0, the bank number is 0 for both reads and writes, so the output address equals the offset.
- R7: When bit 0 of index 2 is 1 (split layout), host reads (host_wr = 0) use bits 5:0 of index 4 as the bank, and host writes use bits 5:0 of index 5.
- R8: When bit 0 of index 2 is 0 (packed layout), host writes use bits 3:0 of index 5 as the bank, and host reads use bits 7:4 of index 5.
- R9: The output address is (bank × 65536 + offset) modulo the memory size. The size is set by bits 1:0 of index 3: 0 is 1 MB, 1 is 2 MB, and 2 or 3 is 4 MB.
- R10: Closing the registers has no effect on the address mapping already set up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the indexed register |
| host_off | input | 16 | Offset of the host access within the window |
| host_wr | input | 1 | 1 for a host write, 0 for a host read |
| mem_addr | output | 22 | Translated video memory address |

## Verification
The hardest condition to reach is a closed lock with non-zero banks already in place. Reset gives all-zero banks, and no write can change a register once the lock is closed. To get there, the bench first opens the lock, programs bank, layout and size values, then closes the lock. It then sweeps host offsets and directions against those stored banks, and also tries writes that should be dropped. The split layout, the packed layout and every size code are each swept over all of their bank values.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
    localparam int IDX_W      = 3;
    localparam int DATA_W     = 8;
    localparam int BANK_W     = 6;
    localparam int OFF_W      = 16;
    localparam int ADDR_W     = BANK_W + OFF_W;
    localparam int MIN_SPAN_W = 20;
    localparam int NIB_W      = DATA_W / 2;

    localparam logic [DATA_W-1:0] KEY_OPEN   = 8'h86;
    localparam logic [DATA_W-1:0] SIG_CLOSED = 8'hA1;
    localparam logic [DATA_W-1:0] SIG_OPEN   = 8'h21;

    typedef enum logic [IDX_W-1:0] {
        IX_KEY   = 3'd0,
        IX_CTRL  = 3'd1,
        IX_BMODE = 3'd2,
        IX_MSIZE = 3'd3,
        IX_RBANK = 3'd4,
        IX_WBANK = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] bmode;
        logic [DATA_W-1:0] msize;
        logic [DATA_W-1:0] rbank;
        logic [DATA_W-1:0] wbank;
    } ext_regs_t;

    // Keep the low address bits that fit in the selected memory size.
    function automatic logic [ADDR_W-1:0] span_mask(input logic [1:0] code);
        logic [ADDR_W-1:0] m;
        int w;
        w = MIN_SPAN_W + ((code > 2'd2) ? 2 : int'(code));
        for (int i = 0; i < ADDR_W; i++) m[i] = (i < w);
        return m;
    endfunction
endpackage

// File: rtl/bwm_regfile.sv
module bwm_regfile
    import bwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              unlocked,
    output ext_regs_t         regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
            regs     <= '0;
        end else if (cfg_wr) begin
            if (reg_idx_e'(cfg_idx) == IX_KEY) begin
                unlocked <= (cfg_wdata == KEY_OPEN);
            end else if (unlocked) begin
                case (reg_idx_e'(cfg_idx))
                    IX_CTRL:  regs.ctrl  <= cfg_wdata;
                    IX_BMODE: regs.bmode <= cfg_wdata;
                    IX_MSIZE: regs.msize <= cfg_wdata;
                    IX_RBANK: regs.rbank <= cfg_wdata;
                    IX_WBANK: regs.wbank <= cfg_wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (reg_idx_e'(cfg_idx) == IX_KEY) begin
            cfg_rdata = unlocked ? SIG_OPEN : SIG_CLOSED;
        end else if (unlocked) begin
            case (reg_idx_e'(cfg_idx))
                IX_CTRL:  cfg_rdata = regs.ctrl;
                IX_BMODE: cfg_rdata = regs.bmode;
                IX_MSIZE: cfg_rdata = regs.msize;
                IX_RBANK: cfg_rdata = regs.rbank;
                IX_WBANK: cfg_rdata = regs.wbank;
                default:  cfg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/bwm_bank_sel.sv
module bwm_bank_sel
    import bwm_pkg::*;
(
    input  logic              bank_en,
    input  logic              split,
    input  logic              host_wr,
    input  logic [BANK_W-1:0] rbank,
    input  logic [DATA_W-1:0] wbank,
    output logic [BANK_W-1:0] bank
);
    localparam int PAD_W = BANK_W - NIB_W;

    logic [BANK_W-1:0] pk_rd, pk_wr;

    // Packed layout: write bank in the low nibble, read bank in the high nibble.
    assign pk_wr = {{PAD_W{1'b0}}, wbank[NIB_W-1:0]};
    assign pk_rd = {{PAD_W{1'b0}}, wbank[DATA_W-1:NIB_W]};

    always_comb begin
        if (!bank_en)   bank = '0;
        else if (split) bank = host_wr ? wbank[BANK_W-1:0] : rbank;
        else            bank = host_wr ? pk_wr : pk_rd;
    end
endmodule

// File: rtl/bwm_addr_wrap.sv
module bwm_addr_wrap
    import bwm_pkg::*;
(
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [1:0]        size_code,
    output logic [ADDR_W-1:0] mem_addr
);
    assign mem_addr = {bank, host_off} & span_mask(size_code);
endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
    import bwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [OFF_W-1:0]  host_off,
    input  logic              host_wr,
    output logic [ADDR_W-1:0] mem_addr
);
    logic              unlocked;
    ext_regs_t         regs;
    logic [BANK_W-1:0] bank;

    bwm_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .unlocked  (unlocked),
        .regs      (regs)
    );

    bwm_bank_sel u_bank (
        .bank_en (regs.ctrl[0]),
        .split   (regs.bmode[0]),
        .host_wr (host_wr),
        .rbank   (regs.rbank[BANK_W-1:0]),
        .wbank   (regs.wbank),
        .bank    (bank)
    );

    bwm_addr_wrap u_wrap (
        .bank      (bank),
        .host_off  (host_off),
        .size_code (regs.msize[1:0]),
        .mem_addr  (mem_addr)
    );
endmodule

// File: rtl/bwm_chk.sv
module bwm_chk
    import bwm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic [IDX_W-1:0]  cfg_idx,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic [OFF_W-1:0]  host_off,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              unlocked,
    input ext_regs_t         regs
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!unlocked && regs == '0));
    // R2
    key_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_idx == IX_KEY) |=> (unlocked == ($past(cfg_wdata) == KEY_OPEN)));
    // R3
    closed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && cfg_wr && cfg_idx != IX_KEY) |=> $stable(regs));
    // R3
    closed_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && cfg_idx != IX_KEY) |-> cfg_rdata == '0);
    // R6
    bank_off_chk: assert property (@(posedge clk) disable iff (rst)
        !regs.ctrl[0] |-> mem_addr[ADDR_W-1:OFF_W] == '0);
    // R9
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        mem_addr[OFF_W-1:0] == host_off);
    // R9
    small_span_chk: assert property (@(posedge clk) disable iff (rst)
        regs.msize[1:0] == 2'd0 |-> mem_addr[ADDR_W-1:MIN_SPAN_W] == '0);
endmodule

bind bank_window_mapper bwm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .host_off  (host_off),
    .mem_addr  (mem_addr),
    .unlocked  (unlocked),
    .regs      (regs)
);

// File: tb/sim_bank_window_mapper.sv
`timescale 1ns/1ps
module sim_bank_window_mapper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_idx = 3'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic [7:0]  cfg_rdata;
    logic [15:0] host_off = 16'd0;
    logic        host_wr = 1'b0;
    logic [21:0] mem_addr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bank_window_mapper u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .host_off(host_off), .host_wr(host_wr), .mem_addr(mem_addr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input int val);
        @(negedge clk);
        cfg_idx = 3'(idx); cfg_wdata = 8'(val); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input int idx, input int exp);
        cfg_idx = 3'(idx);
        #1;
        chk(tag, int'(cfg_rdata), exp);
    endtask

    function automatic int exp_addr(input int bank, input int off, input int sz);
        int w;
        w = 20 + ((sz > 2) ? 2 : sz);
        return (bank * 65536 + off) % (1 << w);
    endfunction

    task automatic map(input string tag, input int off, input int wrd, input int exp);
        host_off = 16'(off); host_wr = wrd[0];
        #1;
        chk(tag, int'(mem_addr), exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd("R1 key", 0, 'hA1);
        wr(0, 'h86);
        for (int i = 1; i < 6; i++) rd("R1 regs", i, 0);
        map("R1 map", 'h1234, 1, 'h1234);
        wr(0, 'h00);
        rd("R2 lock 00", 0, 'hA1);
        wr(0, 'h86);
        rd("R2 open", 0, 'h21);
        wr(0, 'h87);
        rd("R2 other locks", 0, 'hA1);
        wr(0, 'h86);
        // R4 readback
        for (int i = 1; i < 6; i++) begin
            wr(i, 'h5A ^ (i * 37));
            rd("R4 readback", i, ('h5A ^ (i * 37)) & 'hFF);
        end
        rd("R4 idx6", 6, 0);
        rd("R4 idx7", 7, 0);
        // R5 same-cycle read returns old value
        wr(4, 'h00);
        @(negedge clk);
        cfg_idx = 3'd4; cfg_wdata = 8'h15; cfg_wr = 1'b1;
        #1; chk("R5 old value", int'(cfg_rdata), 0);
        @(negedge clk);
        cfg_wr = 1'b0;
        #1; chk("R5 new value", int'(cfg_rdata), 'h15);
        // R6 bank disabled
        wr(1, 'hFE); wr(2, 1); wr(3, 2); wr(4, 'h2A); wr(5, 'h15);
        map("R6 off rd", 'hBEEF, 0, 'hBEEF);
        map("R6 off wr", 'hBEEF, 1, 'hBEEF);
        wr(1, 'h01);
        // R7 split sweep with R9 sizes
        for (int rb = 0; rb < 64; rb++) begin
            wr(4, 'hC0 | rb); wr(5, 'h40 | (63 - rb));
            for (int sz = 0; sz < 4; sz++) begin
                wr(3, 'hFC | sz);
                map("R7 R9 split rd", (rb * 1021) & 'hFFFF, 0, exp_addr(rb, (rb * 1021) & 'hFFFF, sz));
                map("R7 R9 split wr", 'hFFFF, 1, exp_addr(63 - rb, 'hFFFF, sz));
            end
        end
        // R8 packed sweep with R9 sizes
        wr(2, 'hFE);
        for (int v = 0; v < 256; v++) begin
            wr(5, v);
            for (int sz = 0; sz < 4; sz++) begin
                wr(3, sz);
                map("R8 R9 packed wr", v, 1, exp_addr(v & 15, v, sz));
                map("R8 R9 packed rd", 'h8000, 0, exp_addr(v >> 4, 'h8000, sz));
            end
        end
        // R10 and R3: close the lock with mapping in place
        wr(2, 1); wr(3, 2); wr(4, 'h3B); wr(5, 'h07);
        wr(0, 'h00);
        for (int i = 1; i < 8; i++) wr(i, 'hFF);
        map("R10 R3 closed rd", 'h0042, 0, exp_addr('h3B, 'h42, 2));
        map("R10 R3 closed wr", 'h0042, 1, exp_addr('h07, 'h42, 2));
        for (int i = 1; i < 8; i++) rd("R3 closed read", i, 0);
        wr(0, 'h86);
        rd("R3 kept ctrl", 1, 'h01);
        rd("R3 kept rbank", 4, 'h3B);
        rd("R3 kept wbank", 5, 'h07);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule